// File: doc/BRIEF.md
# Receive Frame Buffer Formatter

This block takes an incoming Ethernet frame, one byte per accepted beat, with the frame length given alongside the first byte. It decides at the first byte whether the frame can be kept. If so, it claims a packet page from an external allocator and lays the frame out inside that page: a two-byte status word and a two-byte stored size at the bottom, the frame data from offset 4, zero padding for runt frames, an optional CRC-32 and a final pair of bytes. The last of these carries any odd trailing byte and a control code that tells odd from even length. When the page is complete, the block hands the page number to the receive queue and pulses a receive event.

The CRC-32 is accumulated byte by byte as data and padding are written, so no second pass over the page is needed. The four header bytes are written last, after the trailer. A frame that cannot be kept is still consumed to its last beat, with no page claimed and nothing written. The upstream source holds a frame back while `in_ready` is low, which happens only while a kept frame is being finished.

Top module: `rxf_top`

## Requirements
- R1: While `rx_en` is low or `soft_rst` is high, an offered frame is consumed with `alloc_req` never raised, no memory write and no enqueue.
- R2: A frame whose stored size would exceed 2048 is consumed with no allocation request. A frame whose request is refused (`alloc_gnt` low) is consumed with no write and no enqueue. In both cases `in_ready` stays high up to and after its last beat.
- R3: Stored size S = D + 6, plus 4 more when `strip_crc` is low. D is 64 for frames shorter than 64 bytes, and otherwise the length rounded down to even. S is written little-endian at page bytes 2 (low) and 3 (high), and a kept frame makes exactly S writes, to offsets 0 to S-1.
- R4: Page byte 0 is 0x00. In page byte 1, bit 3 (0x08) is set when the length exceeds 1518, and bit 4 (0x10) is set when the length is odd. All other bits are 0.
- R5: For frames of 64 bytes or more, frame byte i (i < D) is stored at page offset 4 + i, at the page that was granted.
- R6: A frame shorter than 64 bytes stores all its bytes, including an odd last one, from offset 4. Zeros then fill offsets 4 + len up to 67.
- R7: With `strip_crc` low, offsets 4 + D to 7 + D hold the inverted reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) of the D stored data bytes, padding included, least significant byte first.
- R8: Offset S-2 holds the odd last frame byte and offset S-1 holds 0x60 when the length is odd and at least 64. Otherwise offset S-2 holds 0x00 and offset S-1 holds 0x40.
- R9: After the header byte at offset 3 is written, `enq_valid` and `rx_event` pulse together for one cycle, with `enq_page` equal to the granted page.
- R10: `in_ready` drops in the cycle after the last beat of a kept frame is accepted, and rises again only after the enqueue pulse.
- R11: Out of reset, `in_ready` is high and `wr_en`, `alloc_req`, `enq_valid` and `rx_event` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable |
| soft_rst | input | 1 | Soft reset active; frames are dropped |
| strip_crc | input | 1 | High: no CRC is stored |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_len | input | LEN_W | Frame length in bytes, valid with the first byte |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| alloc_req | output | 1 | Page request, raised with the first byte |
| alloc_gnt | input | 1 | Same-cycle grant for `alloc_req` |
| alloc_page | input | PAGE_W | Granted page number |
| wr_en | output | 1 | Memory byte write |
| wr_page | output | PAGE_W | Page being written |
| wr_addr | output | ADDR_W | Byte offset inside the page |
| wr_data | output | 8 | Byte written |
| enq_valid | output | 1 | Push page onto the receive queue |
| enq_page | output | PAGE_W | Page pushed |
| rx_event | output | 1 | Receive-pending event pulse |

## Verification
The bench goes after the runt boundaries (1, 60, 63 and 64 bytes). A design that places the odd runt byte as a trailer, or stops padding early, writes the wrong bytes near offset 67 and the wrong trailer. Odd lengths of 64 and above check that the CRC sits ahead of the held odd byte and that the control code is 0x60. A design that includes the odd byte in the CRC, or writes it at its natural offset, corrupts the CRC field. The size limit is probed on both sides (2039/2040 bytes with CRC, 2043/2044 without); an off-by-one in the limit keeps a frame that should be dropped, or drops one that fits. Lengths of 1518 and 1519 test the long-frame status bit, and the refused-grant and disabled cases catch any write or enqueue that leaks out of a dropped frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_DATA, S_DISC, S_PAD, S_CRC, S_TAIL, S_HDR, S_FIN
    } rxf_state_e;

    localparam int HDR_BYTES    = 4;
    localparam int OVERHEAD     = 6;
    localparam int CRC_BYTES    = 4;
    localparam int ST_LONG_BIT  = 3;
    localparam int ST_ODD_BIT   = 4;
    localparam logic [7:0] CTRL_ODD  = 8'h60;
    localparam logic [7:0] CTRL_EVEN = 8'h40;
endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic [31:0] crc_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o
);
    always_comb begin
        logic [31:0] c;
        c = crc_i ^ {24'h0, data_i};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        crc_o = c;
    end
endmodule

// File: rtl/rxf_size_calc.sv
module rxf_size_calc
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int MIN_LEN    = 64,
    parameter int PAGE_BYTES = 2048,
    localparam int SZ_W      = LEN_W + 1
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic             strip_i,
    output logic [SZ_W-1:0]  dlen_o,
    output logic [SZ_W-1:0]  size_o,
    output logic             too_big_o,
    output logic             short_o,
    output logic             odd_tail_o
);
    logic [SZ_W-1:0] ext;

    always_comb begin
        ext        = SZ_W'(len_i);
        short_o    = ext < SZ_W'(MIN_LEN);
        dlen_o     = short_o ? SZ_W'(MIN_LEN) : {ext[SZ_W-1:1], 1'b0};
        size_o     = dlen_o + SZ_W'(OVERHEAD) + (strip_i ? '0 : SZ_W'(CRC_BYTES));
        too_big_o  = size_o > SZ_W'(PAGE_BYTES);
        odd_tail_o = !short_o && len_i[0];
    end
endmodule

// File: rtl/rxf_top.sv
module rxf_top
    import rxf_pkg::*;
#(
    parameter int PAGE_W     = 2,
    parameter int ADDR_W     = 11,
    parameter int LEN_W      = 12,
    parameter int MIN_LEN    = 64,
    parameter int LONG_LEN   = 1518,
    parameter int PAGE_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              soft_rst,
    input  logic              strip_crc,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [LEN_W-1:0]  in_len,
    output logic              in_ready,
    output logic              alloc_req,
    input  logic              alloc_gnt,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic              wr_en,
    output logic [PAGE_W-1:0] wr_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              enq_valid,
    output logic [PAGE_W-1:0] enq_page,
    output logic              rx_event
);
    localparam int SZ_W = LEN_W + 1;

    typedef struct packed {
        rxf_state_e        st;
        logic [PAGE_W-1:0] page;
        logic [LEN_W-1:0]  len;
        logic [SZ_W-1:0]   dlen;
        logic [SZ_W-1:0]   size;
        logic [SZ_W-1:0]   idx;
        logic [31:0]       crc;
        logic [7:0]        odd_byte;
        logic              odd_tail;
        logic              keep_crc;
        logic [1:0]        cnt;
    } regs_t;

    regs_t r_q, r_d;

    logic [SZ_W-1:0] c_dlen, c_size;
    logic            c_big, c_short, c_oddt;
    logic [31:0]     crc_cur, crc_nxt;
    logic [7:0]      crc_byte;

    rxf_size_calc #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .PAGE_BYTES(PAGE_BYTES)) u_size (
        .len_i(in_len), .strip_i(strip_crc), .dlen_o(c_dlen), .size_o(c_size),
        .too_big_o(c_big), .short_o(c_short), .odd_tail_o(c_oddt)
    );

    always_comb begin
        crc_cur  = (r_q.st == S_IDLE) ? 32'hFFFF_FFFF : r_q.crc;
        crc_byte = (r_q.st == S_PAD) ? 8'h00 : in_data;
    end

    rxf_crc_byte u_crc (.crc_i(crc_cur), .data_i(crc_byte), .crc_o(crc_nxt));

    function automatic rxf_state_e after_data(input logic is_short, input logic keep);
        return is_short ? S_PAD : (keep ? S_CRC : S_TAIL);
    endfunction

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        alloc_req = 1'b0;
        wr_en     = 1'b0;
        wr_page   = r_q.page;
        wr_addr   = '0;
        wr_data   = '0;
        enq_valid = 1'b0;
        rx_event  = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.st = in_last ? S_IDLE : S_DISC;
                    if (rx_en && !soft_rst && !c_big) begin
                        alloc_req = 1'b1;
                        if (alloc_gnt) begin
                            r_d.page     = alloc_page;
                            r_d.len      = in_len;
                            r_d.dlen     = c_dlen;
                            r_d.size     = c_size;
                            r_d.odd_tail = c_oddt;
                            r_d.keep_crc = !strip_crc;
                            r_d.crc      = crc_nxt;
                            r_d.idx      = SZ_W'(1);
                            r_d.cnt      = '0;
                            wr_en        = 1'b1;
                            wr_page      = alloc_page;
                            wr_addr      = ADDR_W'(HDR_BYTES);
                            wr_data      = in_data;
                            r_d.st       = in_last ? after_data(c_short, !strip_crc) : S_DATA;
                        end
                    end
                end
            end
            S_DISC: begin
                in_ready = 1'b1;
                if (in_valid && in_last) r_d.st = S_IDLE;
            end
            S_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (r_q.odd_tail && (r_q.idx == SZ_W'(r_q.len) - SZ_W'(1))) begin
                        r_d.odd_byte = in_data;
                    end else begin
                        wr_en   = 1'b1;
                        wr_addr = ADDR_W'(r_q.idx + SZ_W'(HDR_BYTES));
                        wr_data = in_data;
                        r_d.crc = crc_nxt;
                    end
                    r_d.idx = r_q.idx + SZ_W'(1);
                    if (in_last)
                        r_d.st = after_data(SZ_W'(r_q.len) < SZ_W'(MIN_LEN), r_q.keep_crc);
                end
            end
            S_PAD: begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(r_q.idx + SZ_W'(HDR_BYTES));
                r_d.crc = crc_nxt;
                r_d.idx = r_q.idx + SZ_W'(1);
                if (r_q.idx == r_q.dlen - SZ_W'(1))
                    r_d.st = r_q.keep_crc ? S_CRC : S_TAIL;
            end
            S_CRC: begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(r_q.dlen + SZ_W'(HDR_BYTES) + SZ_W'(r_q.cnt));
                wr_data = 8'((~r_q.crc) >> {r_q.cnt, 3'b000});
                r_d.cnt = r_q.cnt + 2'd1;
                if (r_q.cnt == 2'd3) r_d.st = S_TAIL;
            end
            S_TAIL: begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(r_q.size - SZ_W'(2) + SZ_W'(r_q.cnt));
                if (r_q.cnt == 2'd0) begin
                    wr_data = r_q.odd_tail ? r_q.odd_byte : 8'h00;
                    r_d.cnt = 2'd1;
                end else begin
                    wr_data = r_q.odd_tail ? CTRL_ODD : CTRL_EVEN;
                    r_d.cnt = 2'd0;
                    r_d.st  = S_HDR;
                end
            end
            S_HDR: begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(r_q.cnt);
                r_d.cnt = r_q.cnt + 2'd1;
                case (r_q.cnt)
                    2'd0: wr_data = 8'h00;
                    2'd1: begin
                        wr_data = 8'h00;
                        wr_data[ST_ODD_BIT]  = r_q.len[0];
                        wr_data[ST_LONG_BIT] = SZ_W'(r_q.len) > SZ_W'(LONG_LEN);
                    end
                    2'd2: wr_data = r_q.size[7:0];
                    default: begin
                        wr_data = 8'(r_q.size >> 8);
                        r_d.st  = S_FIN;
                    end
                endcase
            end
            S_FIN: begin
                enq_valid = 1'b1;
                rx_event  = 1'b1;
                r_d.st    = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    assign enq_page = r_q.page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rxf_check.sv
module rxf_check #(
    parameter int PAGE_W = 2,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              soft_rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              alloc_req,
    input logic              wr_en,
    input logic [PAGE_W-1:0] wr_page,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              enq_valid,
    input logic              rx_event
);
    a_r1_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en || soft_rst) |-> !alloc_req);

    a_r2_req_with_offer: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> (in_valid && in_ready));

    a_r9_header_then_enq: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |-> ($past(wr_en) && ($past(wr_addr) == ADDR_W'(3))));

    a_r9_single_enq: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |=> !enq_valid);

    a_r9_event_with_enq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> (enq_valid && !wr_en));

    a_r5_page_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> $stable(wr_page));

    a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_valid) |-> !in_ready);
endmodule

bind rxf_top rxf_check #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst),
    .in_valid(in_valid), .in_ready(in_ready), .alloc_req(alloc_req),
    .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr),
    .enq_valid(enq_valid), .rx_event(rx_event)
);

// File: tb/sim_rxf_top.sv
module sim_rxf_top;
    localparam int PAGE_W = 2;
    localparam int ADDR_W = 11;
    localparam int LEN_W  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, soft_rst = 1'b0, strip_crc = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic in_ready, alloc_req, wr_en, enq_valid, rx_event;
    logic alloc_gnt = 1'b0;
    logic [PAGE_W-1:0] alloc_page = '0, wr_page, enq_page;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0] wr_data;

    always #4 clk = ~clk;

    rxf_top u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst), .strip_crc(strip_crc),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_len(in_len),
        .in_ready(in_ready), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_page(alloc_page),
        .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
        .enq_valid(enq_valid), .enq_page(enq_page), .rx_event(rx_event)
    );

    int checks = 0, fails = 0;
    logic [7:0] mem [0:2047];
    logic [7:0] expv [0:2047];
    logic [7:0] fb [0:2047];
    int wcount, enq_cnt, req_cnt, ev_cnt, last_addr, page_err, seen_page;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: samples 1 ns before each rising edge
    always begin
        @(negedge clk);
        #3;
        if (wr_en) begin
            mem[wr_addr] = wr_data;
            wcount++;
            last_addr = int'(wr_addr);
            if (wr_page != alloc_page) page_err++;
        end
        if (enq_valid) begin enq_cnt++; seen_page = int'(enq_page); end
        if (rx_event) ev_cnt++;
        if (alloc_req) req_cnt++;
    end

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if ((r[0] ^ d[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else r = r >> 1;
        end
        return r;
    endfunction

    task automatic run_frame(input int len, input bit strip, input bit en, input bit srst,
                             input bit gnt, input bit gaps);
        int d, sz, bad;
        bit shrt, oddt, keep, ok;
        logic [31:0] crc;
        shrt = len < 64;
        d    = shrt ? 64 : (len & ~1);
        keep = !strip;
        sz   = d + 6 + (keep ? 4 : 0);
        oddt = !shrt && (len % 2 == 1);
        ok   = en && !srst && gnt && (sz <= 2048);
        for (int i = 0; i < 2048; i++) begin mem[i] = 8'hEE; expv[i] = 8'hEE; end
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        @(negedge clk);
        rx_en = en; soft_rst = srst; strip_crc = strip; alloc_gnt = gnt;
        alloc_page = PAGE_W'($urandom);
        wcount = 0; enq_cnt = 0; req_cnt = 0; ev_cnt = 0; last_addr = -1; page_err = 0;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin in_valid = 1'b0; in_last = 1'b0; @(negedge clk); end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1); in_len = LEN_W'(len);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        #2;
        if (ok) chk(in_ready == 1'b0, "R10 ready low after last beat", int'(in_ready), 0);
        else    chk(in_ready == 1'b1, "R2 dropped frame keeps ready", int'(in_ready), 1);
        for (int w = 0; w < 300 && !in_ready; w++) @(negedge clk);
        @(negedge clk);
        #2;
        if (!ok) begin
            chk(wcount == 0 && enq_cnt == 0, (en && !srst) ? "R2 drop: no write/enqueue" : "R1 drop: no write/enqueue",
                wcount + enq_cnt, 0);
            if (!en || srst) chk(req_cnt == 0, "R1 no allocation request", req_cnt, 0);
            else if (sz > 2048) chk(req_cnt == 0, "R2 oversize no request", req_cnt, 0);
            else chk(req_cnt == 1, "R2 refused request raised once", req_cnt, 1);
            return;
        end
        // expected image
        crc = 32'hFFFF_FFFF;
        for (int i = 0; i < d; i++) begin
            expv[4 + i] = (i < len) ? fb[i] : 8'h00;
            crc = ref_crc(crc, expv[4 + i]);
        end
        if (keep) for (int k = 0; k < 4; k++) expv[4 + d + k] = 8'(~crc >> (8 * k));
        expv[sz - 2] = oddt ? fb[len - 1] : 8'h00;
        expv[sz - 1] = oddt ? 8'h60 : 8'h40;
        expv[0] = 8'h00;
        expv[1] = ((len % 2 == 1) ? 8'h10 : 8'h00) | ((len > 1518) ? 8'h08 : 8'h00);
        expv[2] = 8'(sz);
        expv[3] = 8'(sz >> 8);
        chk(wcount == sz, "R3 write count equals stored size", wcount, sz);
        chk(mem[2] == expv[2] && mem[3] == expv[3], "R3 size field",
            int'({mem[3], mem[2]}), int'({expv[3], expv[2]}));
        chk(mem[0] == expv[0] && mem[1] == expv[1], "R4 status word",
            int'({mem[1], mem[0]}), int'({expv[1], expv[0]}));
        bad = 0;
        for (int i = 4; i < 4 + d; i++) if (mem[i] !== expv[i]) bad++;
        chk(bad == 0 && page_err == 0, shrt ? "R6 runt data and padding" : "R5 frame data",
            bad + page_err, 0);
        if (keep) begin
            bad = 0;
            for (int k = 0; k < 4; k++) if (mem[4 + d + k] !== expv[4 + d + k]) bad++;
            chk(bad == 0, "R7 CRC bytes", int'({mem[7 + d], mem[6 + d], mem[5 + d], mem[4 + d]}), int'(~crc));
        end
        chk(mem[sz - 2] == expv[sz - 2] && mem[sz - 1] == expv[sz - 1], "R8 trailer",
            int'({mem[sz - 2], mem[sz - 1]}), int'({expv[sz - 2], expv[sz - 1]}));
        chk(enq_cnt == 1 && ev_cnt == 1 && seen_page == int'(alloc_page), "R9 enqueue with page",
            seen_page, int'(alloc_page));
        chk(last_addr == 3, "R9 header written last", last_addr, 3);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        #2;
        chk(in_ready == 1'b1, "R11 ready in reset", int'(in_ready), 1);
        chk(!wr_en && !alloc_req && !enq_valid && !rx_event, "R11 outputs idle in reset",
            int'({wr_en, alloc_req, enq_valid, rx_event}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(60,   0, 1, 0, 1, 0);
        run_frame(63,   1, 1, 0, 1, 0);
        run_frame(1,    0, 1, 0, 1, 0);
        run_frame(64,   0, 1, 0, 1, 1);
        run_frame(65,   0, 1, 0, 1, 1);
        run_frame(1518, 1, 1, 0, 1, 0);
        run_frame(1519, 0, 1, 0, 1, 0);
        run_frame(2039, 0, 1, 0, 1, 0);
        run_frame(2040, 0, 1, 0, 1, 0);
        run_frame(2043, 1, 1, 0, 1, 0);
        run_frame(2044, 1, 1, 0, 1, 0);
        run_frame(80,   0, 0, 0, 1, 0);
        run_frame(70,   1, 1, 1, 1, 0);
        run_frame(99,   0, 1, 0, 0, 1);
        for (int n = 0; n < 40; n++) begin
            int len;
            case ($urandom % 3)
                0: len = 1 + ($urandom % 70);
                1: len = 60 + ($urandom % 200);
                default: len = 1510 + ($urandom % 16);
            endcase
            run_frame(len, 1'($urandom), 1'($urandom % 8 != 0), 1'($urandom % 10 == 0),
                      1'($urandom % 8 != 0), 1'b1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule